// File: doc/BRIEF.md
# Sixteen-pin I/O port controller

The block is a sixteen-pin general-purpose I/O port that software controls through 32-bit registers on a simple request/response bus. Each pin has a drive mode, an output type, a slew setting, a bias setting and a 4-bit peripheral-function number. For each pin the block produces pad controls: output level, output enable, open-drain select, pull-up and pull-down enables, slew code and peripheral-function select. The pad inputs pass through a two-stage synchronizer before software can read them.

Software changes output levels in two ways. It can write the output register directly. It can also use a write-only set/clear word, which changes only the pins it names and needs no read-modify-write. Any pin can be marked secure. Bus accesses that do not carry the secure qualifier then cannot change that pin's fields, and they read those fields as zero.

A bus request lasts one cycle. A read returns its data with `bus_rvalid` in the following cycle. A write takes effect at the clock edge where it is presented. The pad controls follow one cycle after that edge.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register is zero. Every pin is then an input with no bias, push-pull, not secure and with output level 0, and all pad outputs are 0.
- R2: A read presented in cycle k returns its data with `bus_rvalid` high in cycle k+1. A write, or a cycle with no request, leaves `bus_rvalid` low in the next cycle.
- R3: Register byte offsets:
  - 0x00: mode
  - 0x04: output type
  - 0x08: slew
  - 0x0C: bias
  - 0x10: input level
  - 0x14: output level
  - 0x18: set/clear
  - 0x20: function low
  - 0x24: function high
  - 0x30: secure flags

  Mode, slew and bias are 2-bit fields at bits [2n+1:2n]. Output type and secure flag are 1 bit at bit n. The function number of pins 0..7 sits at [4n+3:4n] of function low, and that of pins 8..15 at [4(n-8)+3:4(n-8)] of function high. All of these read back as written.
- R4: A write to the set/clear word works per pin. Bit n (n = 0..15) set to 1 drives output level n to 1. Bit n+16 set to 1 drives it to 0. A 0 bit leaves the pin unchanged. If both bits of a pin are 1, the pin is set.
- R5: The set/clear word reads as zero. Writes to the input-level register are ignored. Offsets not listed in R3 read as zero and ignore writes.
- R6: Mode encoding is 00 input, 01 output, 10 peripheral function and 11 analog. `pad_oe[n]` can be high only in mode 01 or 10, and for a push-pull pin in those modes it is high. `pad_out[n]` follows output level n.
- R7: `pad_od[n]` equals the output-type bit, where 1 means open-drain. For an open-drain pin in mode 01 or 10, `pad_oe[n]` is high only while output level n is 0.
- R8: Bias encoding is 01 pull-up (`pad_pu`), 10 pull-down (`pad_pd`), and 00 or 11 neither.
- R9: `fn_en[n]` is high exactly when pin n is in mode 10. `fn_sel[4n+3:4n]` carries the pin's function number, and `pad_slew[2n+1:2n]` its slew field.
- R10: The input-level register reads `pad_in` through two flops. A level applied before edge e1 is returned by a read presented at edge e3, and a read presented at edge e2 still returns the previous level.
- R11: When `bus_secure` is 0, writes leave the fields of secure-flagged pins unchanged in every register, including through the set/clear word. Reads of those fields return zero. Writes to the secure-flag register itself are ignored. The secure-flag register reads fully. An access with `bus_secure` 1 sees and changes every field.
- R12: Every pad output changes one clock edge after the edge at which the register write that affects it takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request valid for one cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access carries the secure qualifier |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Pad output level |
| pad_oe | output | 16 | Pad output enable |
| pad_od | output | 16 | Open-drain select |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |
| pad_slew | output | 32 | 2-bit slew code per pin |
| fn_en | output | 16 | Pin is handed to a peripheral function |
| fn_sel | output | 64 | 4-bit peripheral-function number per pin |

## Verification
Read data is due one edge after the request edge. The driver queues the expected word before presenting the request, and the monitor pops it in the low phase that follows the response edge, so each comparison lands on the cycle R2 defines. Pad outputs are due one edge after the write edge, so the bench waits one full cycle after every configuring write before it compares them. Input levels are due three edges after a pad change: the bench issues one read at the second edge, which must still return the old level, and one at the third edge, which must return the new level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_DRIVE  = 2'b01,
    PM_ALTFN  = 2'b10,
    PM_ANALOG = 2'b11
  } pin_mode_e;

  localparam logic [1:0] BIAS_UP   = 2'b01;
  localparam logic [1:0] BIAS_DOWN = 2'b10;

  localparam int unsigned REG_MODE    = 'h00;
  localparam int unsigned REG_DRVTYPE = 'h04;
  localparam int unsigned REG_SLEW    = 'h08;
  localparam int unsigned REG_BIAS    = 'h0C;
  localparam int unsigned REG_PINS_IN = 'h10;
  localparam int unsigned REG_LEVEL   = 'h14;
  localparam int unsigned REG_SETCLR  = 'h18;
  localparam int unsigned REG_FUNC_LO = 'h20;
  localparam int unsigned REG_FUNC_HI = 'h24;
  localparam int unsigned REG_LOCKSEC = 'h30;

  function automatic logic ofs_mapped(input int unsigned a);
    return (a == REG_MODE) || (a == REG_DRVTYPE) || (a == REG_SLEW) ||
           (a == REG_BIAS) || (a == REG_PINS_IN) || (a == REG_LEVEL) ||
           (a == REG_SETCLR) || (a == REG_FUNC_LO) || (a == REG_FUNC_HI) ||
           (a == REG_LOCKSEC);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_secure,
  input  logic [NPIN-1:0]   in_sync,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  output logic [2*NPIN-1:0] mode_q,
  output logic [NPIN-1:0]   drvtype_q,
  output logic [2*NPIN-1:0] slew_q,
  output logic [2*NPIN-1:0] bias_q,
  output logic [NPIN-1:0]   level_q,
  output logic [4*NPIN-1:0] func_q,
  output logic [NPIN-1:0]   lock_q
);

  localparam int W2   = 2 * NPIN;
  localparam int W4   = 4 * NPIN;
  localparam int HALF = W4 / 2;

  logic [NPIN-1:0] blk1;
  logic [W2-1:0]   blk2;
  logic [W4-1:0]   blk4;

  assign blk1 = bus_secure ? '0 : lock_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_mask
    assign blk2[2*i +: 2] = {2{blk1[i]}};
    assign blk4[4*i +: 4] = {4{blk1[i]}};
  end

  logic wr_en, rd_en;
  assign wr_en = bus_req && bus_wr;
  assign rd_en = bus_req && !bus_wr;

  logic [NPIN-1:0] set_v, clr_v;
  assign set_v = bus_wdata[NPIN-1:0] & ~blk1;
  assign clr_v = bus_wdata[2*NPIN-1:NPIN] & ~blk1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      drvtype_q <= '0;
      slew_q    <= '0;
      bias_q    <= '0;
      level_q   <= '0;
      func_q    <= '0;
      lock_q    <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        AW'(REG_MODE):    mode_q    <= (mode_q & blk2) | (bus_wdata[W2-1:0] & ~blk2);
        AW'(REG_DRVTYPE): drvtype_q <= (drvtype_q & blk1) | (bus_wdata[NPIN-1:0] & ~blk1);
        AW'(REG_SLEW):    slew_q    <= (slew_q & blk2) | (bus_wdata[W2-1:0] & ~blk2);
        AW'(REG_BIAS):    bias_q    <= (bias_q & blk2) | (bus_wdata[W2-1:0] & ~blk2);
        AW'(REG_LEVEL):   level_q   <= (level_q & blk1) | (bus_wdata[NPIN-1:0] & ~blk1);
        AW'(REG_SETCLR):  level_q   <= (level_q & ~clr_v) | set_v;
        AW'(REG_FUNC_LO): func_q[HALF-1:0] <= (func_q[HALF-1:0] & blk4[HALF-1:0]) |
                                              (bus_wdata[HALF-1:0] & ~blk4[HALF-1:0]);
        AW'(REG_FUNC_HI): func_q[W4-1:HALF] <= (func_q[W4-1:HALF] & blk4[W4-1:HALF]) |
                                               (bus_wdata[HALF-1:0] & ~blk4[W4-1:HALF]);
        AW'(REG_LOCKSEC): if (bus_secure) lock_q <= bus_wdata[NPIN-1:0];
        default: ;
      endcase
    end
  end

  logic [DW-1:0] rd_mux;

  always_comb begin
    case (bus_addr)
      AW'(REG_MODE):    rd_mux = DW'(mode_q & ~blk2);
      AW'(REG_DRVTYPE): rd_mux = DW'(drvtype_q & ~blk1);
      AW'(REG_SLEW):    rd_mux = DW'(slew_q & ~blk2);
      AW'(REG_BIAS):    rd_mux = DW'(bias_q & ~blk2);
      AW'(REG_PINS_IN): rd_mux = DW'(in_sync & ~blk1);
      AW'(REG_LEVEL):   rd_mux = DW'(level_q & ~blk1);
      AW'(REG_FUNC_LO): rd_mux = DW'(func_q[HALF-1:0] & ~blk4[HALF-1:0]);
      AW'(REG_FUNC_HI): rd_mux = DW'(func_q[W4-1:HALF] & ~blk4[W4-1:HALF]);
      AW'(REG_LOCKSEC): rd_mux = DW'(lock_q);
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rdata  <= rd_en ? rd_mux : '0;
      bus_rvalid <= rd_en;
    end
  end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*NPIN-1:0] mode_q,
  input  logic [NPIN-1:0]   drvtype_q,
  input  logic [2*NPIN-1:0] slew_q,
  input  logic [2*NPIN-1:0] bias_q,
  input  logic [NPIN-1:0]   level_q,
  input  logic [4*NPIN-1:0] func_q,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_od,
  output logic [NPIN-1:0]   pad_pu,
  output logic [NPIN-1:0]   pad_pd,
  output logic [2*NPIN-1:0] pad_slew,
  output logic [NPIN-1:0]   fn_en,
  output logic [4*NPIN-1:0] fn_sel
);

  logic [NPIN-1:0] oe_n, pu_n, pd_n, fn_n;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pin_mode_e pm;
    logic      drives;
    assign pm      = pin_mode_e'(mode_q[2*i +: 2]);
    assign drives  = (pm == PM_DRIVE) || (pm == PM_ALTFN);
    assign oe_n[i] = drives && !(drvtype_q[i] && level_q[i]);
    assign pu_n[i] = (bias_q[2*i +: 2] == BIAS_UP);
    assign pd_n[i] = (bias_q[2*i +: 2] == BIAS_DOWN);
    assign fn_n[i] = (pm == PM_ALTFN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out  <= '0;
      pad_oe   <= '0;
      pad_od   <= '0;
      pad_pu   <= '0;
      pad_pd   <= '0;
      pad_slew <= '0;
      fn_en    <= '0;
      fn_sel   <= '0;
    end else begin
      pad_out  <= level_q;
      pad_oe   <= oe_n;
      pad_od   <= drvtype_q;
      pad_pu   <= pu_n;
      pad_pd   <= pd_n;
      pad_slew <= slew_q;
      fn_en    <= fn_n;
      fn_sel   <= func_q;
    end
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NPIN = 16,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_secure,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_od,
  output logic [NPIN-1:0]   pad_pu,
  output logic [NPIN-1:0]   pad_pd,
  output logic [2*NPIN-1:0] pad_slew,
  output logic [NPIN-1:0]   fn_en,
  output logic [4*NPIN-1:0] fn_sel
);

  logic [NPIN-1:0]   in_sync;
  logic [2*NPIN-1:0] mode_q, slew_q, bias_q;
  logic [NPIN-1:0]   drvtype_q, level_q, lock_q;
  logic [4*NPIN-1:0] func_q;

  gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (in_sync)
  );

  gpio_regs #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_secure (bus_secure),
    .in_sync    (in_sync),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .mode_q     (mode_q),
    .drvtype_q  (drvtype_q),
    .slew_q     (slew_q),
    .bias_q     (bias_q),
    .level_q    (level_q),
    .func_q     (func_q),
    .lock_q     (lock_q)
  );

  gpio_pad_drive #(.NPIN(NPIN)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .drvtype_q (drvtype_q),
    .slew_q    (slew_q),
    .bias_q    (bias_q),
    .level_q   (level_q),
    .func_q    (func_q),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_od    (pad_od),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .pad_slew  (pad_slew),
    .fn_en     (fn_en),
    .fn_sel    (fn_sel)
  );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NPIN = 16,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_req,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic            bus_rvalid,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_od,
  input logic [NPIN-1:0] pad_pu,
  input logic [NPIN-1:0] pad_pd,
  input logic [NPIN-1:0] fn_en
);

  logic rd_req;
  assign rd_req = bus_req && !bus_wr;

  AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);  // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid);  // R2

  AST_SETCLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (32'(bus_addr) == gpio_pkg::REG_SETCLR)) |=> (bus_rdata == '0));  // R5

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !gpio_pkg::ofs_mapped(32'(bus_addr))) |=> (bus_rdata == '0));  // R5

  AST_OPEN_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pad_od & pad_out & pad_oe) == '0);  // R7

  AST_BIAS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);  // R8

  AST_FUNCTION_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (fn_en & ~pad_oe & ~(pad_od & pad_out)) == '0);  // R9

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pad_od     (pad_od),
  .pad_pu     (pad_pu),
  .pad_pd     (pad_pd),
  .fn_en      (fn_en)
);

// File: tb/gpio_port_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_wr = 1'b0, bus_secure = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd, fn_en;
  logic [31:0] pad_slew;
  logic [63:0] fn_sel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_slew(pad_slew), .fn_en(fn_en), .fn_sel(fn_sel)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic sec);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_secure = sec;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; bus_secure = 1'b1;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic sec, input logic [31:0] exp,
                          input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_secure = sec;
    @(negedge clk);
    bus_req = 1'b0; bus_secure = 1'b1;
  endtask

  // Monitor: pops the scoreboard whenever a response is presented
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected response actual=%h expected=none", bus_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, 64'(bus_rdata), 64'(it.exp));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 pad_oe", 64'(pad_oe), 0);
    check("R1 pad_out", 64'(pad_out | pad_pu | pad_pd | fn_en), 0);
    bus_read(8'h00, 1'b1, 32'h0, "R1 mode reset");
    bus_read(8'h14, 1'b1, 32'h0, "R1 level reset");
    bus_read(8'h30, 1'b1, 32'h0, "R1 secure reset");

    // R3/R6/R9 modes: pin0 out, pin1 function, pin2 analog, pin3 out
    bus_write(8'h00, 32'h0000_0079, 1'b1);
    bus_read(8'h00, 1'b1, 32'h0000_0079, "R3 mode readback");
    check("R12 pad_oe one edge after write", 64'(pad_oe), 64'h000B);
    check("R6 pad_oe modes", 64'(pad_oe), 64'h000B);
    check("R9 fn_en", 64'(fn_en), 64'h0002);

    // R4 set/clear
    bus_write(8'h18, 32'h0000_0005, 1'b1);
    bus_read(8'h14, 1'b1, 32'h5, "R4 set pins 0,2");
    bus_write(8'h18, 32'h0001_0002, 1'b1);
    bus_read(8'h14, 1'b1, 32'h6, "R4 set 1 clear 0");
    bus_write(8'h18, 32'h0002_0009, 1'b1);
    bus_write(8'h18, 32'h0001_0001, 1'b1);
    bus_read(8'h14, 1'b1, 32'hD, "R4 set wins");
    check("R6 pad_out follows level", 64'(pad_out), 64'hD);
    bus_read(8'h18, 1'b1, 32'h0, "R5 setclr reads zero");

    // R7 open drain on pins 0 and 3
    bus_write(8'h04, 32'h0000_0009, 1'b1);
    idle(1);
    check("R7 pad_od", 64'(pad_od), 64'h9);
    check("R7 oe released for high", 64'(pad_oe), 64'h2);
    bus_write(8'h18, 32'h0001_0000, 1'b1);
    idle(1);
    check("R7 oe for low", 64'(pad_oe), 64'h3);

    // R8 bias: pin0 up, pin1 down, pin2 reserved
    bus_write(8'h0C, 32'h0000_0039, 1'b1);
    idle(1);
    check("R8 pad_pu", 64'(pad_pu), 64'h1);
    check("R8 pad_pd", 64'(pad_pd), 64'h2);

    // R3/R9 function numbers and slew
    bus_write(8'h20, 32'h0000_00A0, 1'b1);
    bus_write(8'h24, 32'h5000_0000, 1'b1);
    bus_write(8'h08, 32'h0000_0003, 1'b1);
    bus_read(8'h24, 1'b1, 32'h5000_0000, "R3 function high readback");
    bus_read(8'h20, 1'b1, 32'h0000_00A0, "R3 function low readback");
    bus_read(8'h08, 1'b1, 32'h3, "R3 slew readback");
    check("R9 fn_sel", fn_sel, 64'h5000_0000_0000_00A0);
    check("R9 pad_slew", 64'(pad_slew), 64'h3);

    // R10 synchronizer latency
    pad_in = 16'hA5A5;
    idle(1);
    bus_read(8'h10, 1'b1, 32'h0, "R10 old level at second edge");
    bus_read(8'h10, 1'b1, 32'hA5A5, "R10 new level at third edge");

    // R5 ignored writes
    bus_write(8'h10, 32'h0000_0000, 1'b1);
    bus_read(8'h10, 1'b1, 32'hA5A5, "R5 input write ignored");
    bus_write(8'h2C, 32'hFFFF_FFFF, 1'b1);
    bus_read(8'h2C, 1'b1, 32'h0, "R5 unmapped reads zero");

    // R11 secure pin 0
    bus_write(8'h30, 32'h0000_0001, 1'b1);
    bus_write(8'h00, 32'hFFFF_FFFF, 1'b0);
    bus_read(8'h00, 1'b1, 32'hFFFF_FFFD, "R11 secure field kept");
    bus_read(8'h00, 1'b0, 32'hFFFF_FFFC, "R11 nonsecure read masked");
    bus_write(8'h18, 32'h0000_0001, 1'b0);
    bus_read(8'h14, 1'b1, 32'hC, "R11 nonsecure set ignored");
    bus_write(8'h30, 32'h0000_0000, 1'b0);
    bus_read(8'h30, 1'b0, 32'h1, "R11 secure flags kept");
    bus_read(8'h10, 1'b0, 32'hA5A4, "R11 input read masked");
    check("R11 pad_oe only pin0", 64'(pad_oe), 64'h1);

    idle(3);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing responses actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule